// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block is the byte-wide register file that holds the settings of a temperature and fan monitoring controller. An upstream bus agent reaches it through a plain register port: an address, a write data byte, a write strobe, a read strobe and a registered read data byte. The bank holds one configuration register and a parameterised row of limit registers. The limits sit at consecutive addresses starting at a base address, and their values are brought out on a flat bus for the comparison logic downstream.

The configuration register carries a one-way protection bit. Once software writes a 1 to it, every register marked as protected refuses later writes until a synchronous reset. Reads still return the stored contents. A per-register mask parameter marks which limit registers are protected. Inside the configuration register, the monitor-enable and force-full-speed bits stay writable after protection. A hardware ready flag, set from an input, occupies one bit of the same register. A self-clearing bit in that register requests a clear of latched alarm conditions elsewhere in the chip.

Top module: `lockable_reg_bank`

## Requirements
- R1: After reset the configuration register reads 0x01 (bit 0 set, every other bit clear), every limit register reads 0xFF, `locked` is 0 and `rdata` is 0x00.
- R2: Configuration bit 0 (`mon_en`) and bit 3 (`force_max`) take the written value on every write to the configuration address (0x00), whether or not the bank is locked. Both are visible on their output ports one cycle after the write strobe.
- R3: Writing 1 to configuration bit 1 sets `locked` from the next cycle on. Writing 0 to that bit never clears it, and only reset does.
- R4: Configuration bit 2 is a read-only ready flag. It becomes 1 the cycle after `hw_ready` is sampled high, stays 1 until reset, and ignores writes.
- R5: Configuration bits 4, 5 and 6 (`pwr_mon_en`, `spinup_dis`, `bus_tmo_en`) take written values only while unlocked. After lock they keep their values.
- R6: Writing 1 to configuration bit 7 raises `latch_clr` for exactly the cycle after that write, locked or not. Bit 7 always reads back as 0.
- R7: Limit register i (address base 0x20 plus i) whose bit in `LOCK_MASK` (default 0x3F) is 1 takes writes only while unlocked. Writes after lock are dropped, and reads return the stored value.
- R8: Limit registers whose `LOCK_MASK` bit is 0 take writes at any time. Each limit value appears on `limits[8*i+7:8*i]` one cycle after its write.
- R9: `rdata` is loaded on a cycle with `rd_en` and appears the next cycle. It shows the contents from before any write in the same cycle, and holds when `rd_en` is low. Addresses other than 0x00 and the limit range read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| hw_ready | input | 1 | Hardware power-up complete indication |
| rdata | output | 8 | Registered read data |
| locked | output | 1 | Protection active |
| mon_en | output | 1 | Monitoring from programmed limits enabled |
| force_max | output | 1 | Run all fans at programmed maximum |
| pwr_mon_en | output | 1 | Core power monitoring enable |
| spinup_dis | output | 1 | Fan spin-up pulse sequence disabled |
| bus_tmo_en | output | 1 | Bus timeout enable |
| latch_clr | output | 1 | One-cycle request to clear latched alarms |
| limits | output | NUM_LIMITS*8 (64) | All limit register values, register i in bits 8*i+7:8*i |

## Verification
A lock bit that drops or fails to set would show on `locked` in the cycle after the offending write. It would also show as a protected limit or configuration field taking a value it should have refused, which is visible on `limits` or on the field outputs one cycle later. A wrong ready flag or a stuck bit 7 stays hidden until a read of address 0x00, and then shows on `rdata` one cycle after the read strobe. The reference model in the bench tracks every register and every output on each clock, so any divergence is caught within one cycle of the port that first exposes it.

// File: rtl/rb_pkg.sv
package rb_pkg;
    localparam int DW = 8;
    localparam int AW = 8;

    typedef logic [DW-1:0] byte_t;
    typedef logic [AW-1:0] addr_t;

    typedef struct packed {
        logic latch_rst;
        logic bus_tmo_en;
        logic spinup_dis;
        logic pwr_mon_en;
        logic force_max;
        logic ready;
        logic lock;
        logic mon_en;
    } cfg_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_LIM
    } sel_e;

    localparam addr_t CFG_ADDR          = 8'h00;
    localparam byte_t CFG_RESET         = 8'h01;
    localparam byte_t CFG_FREE_MASK     = 8'h09;
    localparam byte_t CFG_LOCKABLE_MASK = 8'h70;

    function automatic byte_t cfg_wmask(logic is_locked);
        return is_locked ? CFG_FREE_MASK : (CFG_FREE_MASK | CFG_LOCKABLE_MASK);
    endfunction
endpackage

// File: rtl/rb_decode.sv
module rb_decode
    import rb_pkg::*;
#(
    parameter int    NUM_LIMITS = 8,
    parameter addr_t LIM_BASE   = 8'h20,
    localparam int   IW         = $clog2(NUM_LIMITS)
) (
    input  addr_t          addr,
    output sel_e           sel,
    output logic [IW-1:0]  idx
);
    addr_t off;

    always_comb begin
        off = addr - LIM_BASE;
        idx = off[IW-1:0];
        if (addr == CFG_ADDR)
            sel = SEL_CFG;
        else if (off < AW'(NUM_LIMITS))
            sel = SEL_LIM;
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/rb_cfg_reg.sv
module rb_cfg_reg
    import rb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_cfg,
    input  byte_t wdata,
    input  logic  hw_ready,
    output cfg_t  q,
    output logic  latch_clr
);
    byte_t wmask;
    cfg_t  nxt;

    always_comb begin
        wmask         = cfg_wmask(q.lock);
        nxt           = cfg_t'((byte_t'(q) & ~wmask) | (wdata & wmask));
        nxt.lock      = q.lock | wdata[1];
        nxt.ready     = q.ready | hw_ready;
        nxt.latch_rst = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q         <= cfg_t'(CFG_RESET);
            latch_clr <= 1'b0;
        end else begin
            if (wr_cfg)
                q <= nxt;
            q.ready   <= q.ready | hw_ready;
            latch_clr <= wr_cfg & wdata[7];
        end
    end
endmodule

// File: rtl/rb_limit_bank.sv
module rb_limit_bank
    import rb_pkg::*;
#(
    parameter int                    NUM_LIMITS = 8,
    parameter logic [NUM_LIMITS-1:0] LOCK_MASK  = 8'h3F,
    parameter byte_t                 RESET_VAL  = 8'hFF,
    localparam int                   IW         = $clog2(NUM_LIMITS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_lim,
    input  logic [IW-1:0]              idx,
    input  logic                       locked,
    input  byte_t                      wdata,
    output logic [NUM_LIMITS*DW-1:0]   flat
);
    for (genvar i = 0; i < NUM_LIMITS; i++) begin : g_lim
        logic allow;
        logic we;
        assign allow = !locked || !LOCK_MASK[i];
        assign we    = wr_lim && (idx == IW'(i)) && allow;

        always_ff @(posedge clk) begin
            if (rst)
                flat[i*DW +: DW] <= RESET_VAL;
            else if (we)
                flat[i*DW +: DW] <= wdata;
        end
    end
endmodule

// File: rtl/lockable_reg_bank.sv
module lockable_reg_bank
    import rb_pkg::*;
#(
    parameter int                    NUM_LIMITS = 8,
    parameter logic [NUM_LIMITS-1:0] LOCK_MASK  = 8'h3F,
    parameter logic [7:0]            LIM_BASE   = 8'h20,
    localparam int                   IW         = $clog2(NUM_LIMITS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              addr,
    input  logic [7:0]              wdata,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic                    hw_ready,
    output logic [7:0]              rdata,
    output logic                    locked,
    output logic                    mon_en,
    output logic                    force_max,
    output logic                    pwr_mon_en,
    output logic                    spinup_dis,
    output logic                    bus_tmo_en,
    output logic                    latch_clr,
    output logic [NUM_LIMITS*8-1:0] limits
);
    sel_e          sel;
    logic [IW-1:0] idx;
    cfg_t          cfg_q;

    rb_decode #(.NUM_LIMITS(NUM_LIMITS), .LIM_BASE(LIM_BASE)) u_dec (
        .addr (addr),
        .sel  (sel),
        .idx  (idx)
    );

    rb_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr_cfg    (wr_en && (sel == SEL_CFG)),
        .wdata     (wdata),
        .hw_ready  (hw_ready),
        .q         (cfg_q),
        .latch_clr (latch_clr)
    );

    rb_limit_bank #(.NUM_LIMITS(NUM_LIMITS), .LOCK_MASK(LOCK_MASK)) u_lim (
        .clk    (clk),
        .rst    (rst),
        .wr_lim (wr_en && (sel == SEL_LIM)),
        .idx    (idx),
        .locked (cfg_q.lock),
        .wdata  (wdata),
        .flat   (limits)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en) begin
            unique case (sel)
                SEL_CFG: rdata <= byte_t'(cfg_q);
                SEL_LIM: rdata <= limits[idx*DW +: DW];
                default: rdata <= '0;
            endcase
        end
    end

    assign locked     = cfg_q.lock;
    assign mon_en     = cfg_q.mon_en;
    assign force_max  = cfg_q.force_max;
    assign pwr_mon_en = cfg_q.pwr_mon_en;
    assign spinup_dis = cfg_q.spinup_dis;
    assign bus_tmo_en = cfg_q.bus_tmo_en;
endmodule

// File: rtl/rb_checker.sv
module rb_checker
    import rb_pkg::*;
#(
    parameter int                    NUM_LIMITS = 8,
    parameter logic [NUM_LIMITS-1:0] LOCK_MASK  = 8'h3F
) (
    input logic                    clk,
    input logic                    rst,
    input logic [7:0]              addr,
    input logic [7:0]              wdata,
    input logic                    wr_en,
    input logic                    locked,
    input logic                    mon_en,
    input logic                    force_max,
    input logic                    pwr_mon_en,
    input logic                    spinup_dis,
    input logic                    bus_tmo_en,
    input logic                    latch_clr,
    input logic [NUM_LIMITS*8-1:0] limits
);
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked);

    p_lock_cause_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $rose(locked)) |-> $past(wr_en && addr == CFG_ADDR && wdata[1]));

    p_free_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en && addr == CFG_ADDR))
            |-> (mon_en == $past(wdata[0]) && force_max == $past(wdata[3])));

    p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(locked)) |-> $stable({pwr_mon_en, spinup_dis, bus_tmo_en}));

    p_latch_cause_r6: assert property (@(posedge clk) disable iff (rst)
        latch_clr |-> $past(wr_en && addr == CFG_ADDR && wdata[7]));

    for (genvar i = 0; i < NUM_LIMITS; i++) begin : g_frz
        if (LOCK_MASK[i]) begin : g_on
            p_lim_frozen_r7: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(locked)) |-> $stable(limits[i*8 +: 8]));
        end
    end
endmodule

bind lockable_reg_bank rb_checker #(.NUM_LIMITS(NUM_LIMITS), .LOCK_MASK(LOCK_MASK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wdata      (wdata),
    .wr_en      (wr_en),
    .locked     (locked),
    .mon_en     (mon_en),
    .force_max  (force_max),
    .pwr_mon_en (pwr_mon_en),
    .spinup_dis (spinup_dis),
    .bus_tmo_en (bus_tmo_en),
    .latch_clr  (latch_clr),
    .limits     (limits)
);

// File: tb/sim_lockable_reg_bank.sv
`timescale 1ns/1ps
module sim_lockable_reg_bank;
    localparam int   N     = 8;
    localparam int   LMASK = 8'h3F;
    localparam int   BASE  = 8'h20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] addr = '0, wdata = '0;
    logic wr_en = 1'b0, rd_en = 1'b0, hw_ready = 1'b0;
    logic [7:0] rdata;
    logic locked, mon_en, force_max, pwr_mon_en, spinup_dis, bus_tmo_en, latch_clr;
    logic [N*8-1:0] limits;

    always #5 clk = ~clk;

    lockable_reg_bank u0 (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .hw_ready(hw_ready), .rdata(rdata), .locked(locked),
        .mon_en(mon_en), .force_max(force_max), .pwr_mon_en(pwr_mon_en),
        .spinup_dis(spinup_dis), .bus_tmo_en(bus_tmo_en), .latch_clr(latch_clr),
        .limits(limits)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit started = 0, done = 0;

    // behavioural reference state
    int m_mon, m_lock, m_rdy, m_force, m_lk, m_lclr, m_rd;
    int m_lim [N];

    function automatic int m_cfg();
        return (m_lk << 4) | (m_force << 3) | (m_rdy << 2) | (m_lock << 1) | m_mon;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        int a, d, off;
        started = 1;
        cyc++;
        a = addr; d = wdata; off = a - BASE;
        if (rst) begin
            m_mon = 1; m_lock = 0; m_rdy = 0; m_force = 0; m_lk = 0; m_lclr = 0; m_rd = 0;
            foreach (m_lim[i]) m_lim[i] = 8'hFF;
        end else begin
            if (rd_en) begin
                if (a == 0) m_rd = m_cfg();
                else if (off >= 0 && off < N) m_rd = m_lim[off];
                else m_rd = 0;
            end
            m_lclr = (wr_en && a == 0 && d[7]) ? 1 : 0;
            if (hw_ready) m_rdy = 1;
            if (wr_en) begin
                if (a == 0) begin
                    m_mon = d[0];
                    m_force = d[3];
                    if (m_lock == 0) m_lk = (d >> 4) & 7;
                    if (d[1]) m_lock = 1;
                end else if (off >= 0 && off < N) begin
                    if (m_lock == 0 || ((LMASK >> off) & 1) == 0) m_lim[off] = d;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            check("R9 rdata", rdata, m_rd);
            check("R3 locked", locked, m_lock);
            check("R2 mon_en", mon_en, m_mon);
            check("R2 force_max", force_max, m_force);
            check("R5 lockable cfg bits", {bus_tmo_en, spinup_dis, pwr_mon_en}, m_lk);
            check("R6 latch_clr", latch_clr, m_lclr);
            for (int i = 0; i < N; i++)
                check(((LMASK >> i) & 1) ? "R7 limit" : "R8 limit", limits[i*8 +: 8], m_lim[i]);
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic op(input bit w, input bit r, input int a, input int d);
        wr_en = w; rd_en = r; addr = 8'(a); wdata = 8'(d);
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        op(0, 1, a, 0);
        check(tag, rdata, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        check("R1 locked after reset", locked, 0);
        check("R1 rdata after reset", rdata, 0);
        rd(8'h00, 8'h01, "R1 cfg reset");
        rd(BASE, 8'hFF, "R1 limit0 reset");
        rd(BASE + N - 1, 8'hFF, "R1 last limit reset");
        rd(8'h05, 8'h00, "R9 unmapped");
        rd(BASE + N, 8'h00, "R9 past limit range");
        // R4 ready flag
        hw_ready = 1; @(negedge clk); hw_ready = 0;
        rd(8'h00, 8'h05, "R4 ready set");
        op(1, 0, 8'h00, 8'h00);
        rd(8'h00, 8'h04, "R4 ready not writable");
        // R5 unlocked write of lockable bits, R2 free bits
        op(1, 0, 8'h00, 8'h78);
        rd(8'h00, 8'h7C, "R5 cfg unlocked write");
        // R6 latch clear pulse
        op(1, 0, 8'h00, 8'h81);
        check("R6 latch pulse", latch_clr, 1);
        @(negedge clk);
        check("R6 latch one cycle", latch_clr, 0);
        rd(8'h00, 8'h05, "R6 bit7 reads 0");
        // limits before lock
        for (int i = 0; i < N; i++) op(1, 0, BASE + i, 8'h10 + i);
        for (int i = 0; i < N; i++) rd(BASE + i, 8'h10 + i, "R7 limit write unlocked");
        // lock
        op(1, 0, 8'h00, 8'h73);
        check("R3 lock set", locked, 1);
        rd(8'h00, 8'h77, "R3 cfg after lock");
        op(1, 0, 8'h00, 8'h08);
        rd(8'h00, 8'h7E, "R2 free bits after lock");
        op(1, 0, 8'h00, 8'h00);
        rd(8'h00, 8'h76, "R3 lock not cleared R5 frozen");
        for (int i = 0; i < N; i++) op(1, 0, BASE + i, 8'hA0 + i);
        for (int i = 0; i < N; i++)
            rd(BASE + i, (((LMASK >> i) & 1) ? 8'h10 : 8'hA0) + i,
               ((LMASK >> i) & 1) ? "R7 locked limit dropped" : "R8 unlocked limit written");
        // R9 read and write in the same cycle
        op(1, 1, BASE + 6, 8'h55);
        check("R9 read before write", rdata, 8'hA6);
        @(negedge clk);
        check("R9 rdata holds", rdata, 8'hA6);
        rd(BASE + 6, 8'h55, "R8 write landed");
        op(1, 0, 8'h00, 8'h80);
        check("R6 latch while locked", latch_clr, 1);
        rd(8'h00, 8'h76, "R6 cfg unchanged");
        // reset clears lock
        rst = 1; repeat (2) @(negedge clk); rst = 0;
        check("R3 lock cleared by reset", locked, 0);
        rd(8'h00, 8'h01, "R1 cfg after second reset");
        op(1, 0, BASE, 8'h33);
        rd(BASE, 8'h33, "R7 writable after reset");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule